// File: doc/BRIEF.md
# CPU Clock Speed Controller

This block decides how fast a processor core runs and which clock source feeds it. It operates in the domain of the selected source clock. It sends the core a one-cycle enable pulse once every 2^e source cycles, and it sends the timers an enable that never divides. Its outputs name which of three sources must be routed to the clock tree: main oscillator, low-speed real-time oscillator or PLL output. They also request that the main oscillator or the PLL be powered down. Nothing else in the block touches the analog side.

Software changes the speed with one command word on a valid/ready channel. Each word carries:
- a 3-bit divide exponent;
- a source code;
- two power-down flags, one for the main oscillator and one for the PLL;
- a target bit that chooses between the normal setting and the interrupt setting.

The channel is ready only on core-enable cycles, so the core executes the command at the speed that was in force before it. When valid is high and ready is low, the sender must hold the word stable. A word is consumed on the first cycle with both valid and ready high. There is no other back-pressure.

The block counts interrupt entries and returns. While the nesting depth is above zero, it runs on the interrupt setting. When the outermost handler returns, it goes back to the normal setting. Every change of setting, whether it comes from a command or from the interrupt state, takes effect only when the divider count wraps. As a result, no enable period is ever cut short.

Top module: `cpu_speed_ctrl`

## Requirements
- R1: After reset the active source code is 0 (main oscillator), `osc_en` and `pll_en` are 1, `core_ce` is high on every cycle, and the interrupt setting equals the normal setting.
- R2: With divide exponent e (3-bit field, 0 to 7), `core_ce` is a single-cycle pulse repeating every 2^e cycles, so the divisors run from 1 to 128.
- R3: `timer_ce` is high on every cycle, whatever the divisor.
- R4: Source codes are 0 = main oscillator, 1 = real-time oscillator, 2 = PLL, and 3 = reserved. `src_sel` shows the code of the active setting.
- R5: `osc_en` is the inverse of the active setting's main-oscillator-off flag, and `pll_en` is the inverse of its PLL-off flag.
- R6: `cmd_ready` is high exactly on `core_ce` cycles. The period that starts at the accepting pulse keeps the old divisor, and the new divisor governs the period after it.
- R7: The block rejects a command with source code 3, a command with source 0 and the main-oscillator-off flag set, and a command with source 2 and the PLL-off flag set. A rejected command leaves both stored settings unchanged.
- R8: `cmd_target` = 0 writes the normal setting and `cmd_target` = 1 writes the interrupt setting. Writing one setting does not alter the other.
- R9: When the depth goes from 0 to 1 on `irq_enter`, the interrupt setting becomes active at the next divider wrap. When the depth returns to 0, the normal setting is restored at the next wrap.
- R10: Nested entries raise the depth and returns lower it. Only the return that brings the depth to 0 restores the normal setting. A return at depth 0 is ignored, and an entry at the maximum depth (2^DEPTH_W - 1) is ignored.
- R11: When `irq_enter` and `irq_return` arrive in the same cycle, the depth does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Selected source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Speed command present |
| cmd_ready | output | 1 | Command accepted on this cycle if valid |
| cmd_target | input | 1 | 0 = normal setting, 1 = interrupt setting |
| cmd_div_exp | input | 3 | Divide exponent, divisor = 2^value |
| cmd_src | input | 2 | Source code |
| cmd_osc_off | input | 1 | Power down the main oscillator |
| cmd_pll_off | input | 1 | Power down the PLL |
| irq_enter | input | 1 | Pulse on interrupt service entry |
| irq_return | input | 1 | Pulse on return from interrupt |
| core_ce | output | 1 | Core clock enable pulse |
| timer_ce | output | 1 | Undivided timer enable |
| src_sel | output | 2 | Active source code |
| osc_en | output | 1 | Main oscillator enable |
| pll_en | output | 1 | PLL enable |

## Verification
The bench counts the cycles from accepting a command to the next pulse. A design that applied a new divisor at once, instead of at the wrap, would produce a period that is too short or too long there.

It sends each of the three illegal source and power-down combinations. A design that stored any of them would change the measured period or `src_sel`, or would run from a powered-down source.

For the interrupt path, the bench covers nested entries, a stray return at depth 0, entry beyond the saturation depth, and simultaneous entry and return. A depth counter that wraps or underflows, or that gives one edge priority over the other, would come back to the wrong setting, and the period measurement shows it.

// File: rtl/spd_pkg.sv
package spd_pkg;
  parameter int SPD_EXP_W = 3;

  typedef enum logic [1:0] {
    SRC_MAIN = 2'd0,
    SRC_RTC  = 2'd1,
    SRC_PLL  = 2'd2,
    SRC_RSVD = 2'd3
  } src_e;

  typedef struct packed {
    src_e                 src;
    logic                 main_off;
    logic                 pll_off;
    logic [SPD_EXP_W-1:0] exp;
  } speed_cfg_t;

  localparam speed_cfg_t CFG_RESET = '{src: SRC_MAIN, main_off: 1'b0,
                                       pll_off: 1'b0, exp: '0};

  function automatic logic cfg_ok(speed_cfg_t c);
    return (c.src != SRC_RSVD)
        && !(c.src == SRC_MAIN && c.main_off)
        && !(c.src == SRC_PLL && c.pll_off);
  endfunction
endpackage

// File: rtl/spd_cfg_bank.sv
module spd_cfg_bank
  import spd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_isr,
  input  speed_cfg_t wr_cfg,
  output speed_cfg_t norm_cfg,
  output speed_cfg_t isr_cfg
);
  localparam int SLOTS = 2;

  speed_cfg_t slot_q [SLOTS];
  logic       wr_legal;

  assign wr_legal = cfg_ok(wr_cfg);

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[g] <= CFG_RESET;
      end else if (wr_en && wr_legal && (wr_isr == (g == 1))) begin
        slot_q[g] <= wr_cfg;
      end
    end
  end

  assign norm_cfg = slot_q[0];
  assign isr_cfg  = slot_q[1];

  AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_legal) |=> ($stable(slot_q[0]) && $stable(slot_q[1]))); // R7
  AST_NORM_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ok(slot_q[0])); // R7
  AST_OTHER_SLOT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_isr) |=> $stable(slot_q[0])); // R8
endmodule

// File: rtl/spd_nest_track.sv
module spd_nest_track #(
  parameter int DEPTH_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enter,
  input  logic ret,
  output logic in_isr
);
  localparam logic [DEPTH_W-1:0] DEPTH_MAX = '1;

  logic [DEPTH_W-1:0] depth_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth_q <= '0;
    end else begin
      unique case ({enter, ret})
        2'b10:   if (depth_q != DEPTH_MAX) depth_q <= depth_q + 1'b1;
        2'b01:   if (depth_q != '0) depth_q <= depth_q - 1'b1;
        default: depth_q <= depth_q;
      endcase
    end
  end

  assign in_isr = (depth_q != '0);

  AST_DEPTH_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
    (enter && !ret && depth_q == DEPTH_MAX) |=> (depth_q == DEPTH_MAX)); // R10
  AST_DEPTH_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && !enter && depth_q == '0) |=> (depth_q == '0)); // R10
  AST_DEPTH_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (enter && ret) |=> $stable(depth_q)); // R11
endmodule

// File: rtl/spd_divider.sv
module spd_divider
  import spd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  speed_cfg_t target,
  output logic       core_ce,
  output speed_cfg_t active
);
  localparam int CNT_W = (1 << SPD_EXP_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  speed_cfg_t       act_q;

  function automatic logic [CNT_W-1:0] span_m1(logic [SPD_EXP_W-1:0] e);
    logic [CNT_W:0] one;
    one = 1;
    return CNT_W'((one << e) - 1'b1);
  endfunction

  assign core_ce = (cnt_q == '0);
  assign active  = act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= CFG_RESET;
    end else if (core_ce) begin
      cnt_q <= span_m1(target.exp);
      act_q <= target;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  AST_CE_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    !core_ce |=> (cnt_q == $past(cnt_q) - 1'b1)); // R2
  AST_ACTIVE_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !core_ce |=> $stable(act_q)); // R6
  AST_ACTIVE_SRC_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !((act_q.src == SRC_MAIN && act_q.main_off) ||
      (act_q.src == SRC_PLL && act_q.pll_off) ||
      (act_q.src == SRC_RSVD))); // R7
endmodule

// File: rtl/cpu_speed_ctrl.sv
module cpu_speed_ctrl
  import spd_pkg::*;
#(
  parameter int DEPTH_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic                 cmd_target,
  input  logic [SPD_EXP_W-1:0] cmd_div_exp,
  input  logic [1:0]           cmd_src,
  input  logic                 cmd_osc_off,
  input  logic                 cmd_pll_off,
  input  logic                 irq_enter,
  input  logic                 irq_return,
  output logic                 core_ce,
  output logic                 timer_ce,
  output logic [1:0]           src_sel,
  output logic                 osc_en,
  output logic                 pll_en
);
  speed_cfg_t wr_cfg, norm_cfg, isr_cfg, target, active;
  logic       in_isr, wr_en;

  assign wr_cfg = '{src: src_e'(cmd_src), main_off: cmd_osc_off,
                    pll_off: cmd_pll_off, exp: cmd_div_exp};
  assign cmd_ready = core_ce;
  assign wr_en     = cmd_valid && core_ce;

  spd_cfg_bank u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_isr(cmd_target),
    .wr_cfg(wr_cfg), .norm_cfg(norm_cfg), .isr_cfg(isr_cfg)
  );

  spd_nest_track #(.DEPTH_W(DEPTH_W)) u_nest (
    .clk(clk), .rst_n(rst_n), .enter(irq_enter), .ret(irq_return),
    .in_isr(in_isr)
  );

  assign target = in_isr ? isr_cfg : norm_cfg;

  spd_divider u_div (
    .clk(clk), .rst_n(rst_n), .target(target), .core_ce(core_ce),
    .active(active)
  );

  assign timer_ce = 1'b1;
  assign src_sel  = active.src;
  assign osc_en   = !active.main_off;
  assign pll_en   = !active.pll_off;

  AST_SWITCH_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (core_ce && $changed(src_sel)) |-> $past(core_ce)); // R9
endmodule

// File: tb/test_cpu_speed_ctrl.sv
module test_cpu_speed_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_target = 1'b0, cmd_osc_off = 1'b0, cmd_pll_off = 1'b0;
  logic [2:0] cmd_div_exp = '0;
  logic [1:0] cmd_src = '0;
  logic irq_enter = 1'b0, irq_return = 1'b0;
  logic cmd_ready, core_ce, timer_ce, osc_en, pll_en;
  logic [1:0] src_sel;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_speed_ctrl i_cpu_speed_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_target(cmd_target), .cmd_div_exp(cmd_div_exp), .cmd_src(cmd_src),
    .cmd_osc_off(cmd_osc_off), .cmd_pll_off(cmd_pll_off),
    .irq_enter(irq_enter), .irq_return(irq_return), .core_ce(core_ce),
    .timer_ce(timer_ce), .src_sel(src_sel), .osc_en(osc_en), .pll_en(pll_en)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input bit tgt, input int e, input int s, input bit mo, input bit po);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_target = tgt; cmd_div_exp = 3'(e);
    cmd_src = 2'(s); cmd_osc_off = mo; cmd_pll_off = po;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_pulse(output int k);
    k = 0;
    while (!core_ce) begin @(negedge clk); k++; end
  endtask

  task automatic measure(output int p);
    int k;
    wait_pulse(k);
    p = 0;
    do begin @(negedge clk); p++; end while (!core_ce);
  endtask

  task automatic irq(input bit en, input bit rt);
    @(negedge clk);
    irq_enter = en; irq_return = rt;
    @(negedge clk);
    irq_enter = 1'b0; irq_return = 1'b0;
  endtask

  task automatic t_reset;
    int p;
    @(negedge clk);
    chk(src_sel == 2'd0, "R1 src", src_sel, 0);
    chk(osc_en && pll_en, "R1 enables", {osc_en, pll_en}, 3);
    chk(core_ce == 1'b1, "R1 ce", core_ce, 1);
    measure(p);
    chk(p == 1, "R1 period", p, 1);
    irq(1'b1, 1'b0);
    measure(p);
    chk(p == 1 && src_sel == 2'd0, "R1 isr equals normal", p, 1);
    irq(1'b0, 1'b1);
  endtask

  task automatic t_div_sweep;
    int p, k, old_p, hi;
    old_p = 1;
    for (int e = 0; e < 8; e++) begin
      send(1'b0, e, 0, 1'b0, 1'b0);
      wait_pulse(k);
      chk(k == old_p - 1, "R6 old divisor holds", k, old_p - 1);
      measure(p);
      chk(p == (1 << e), "R2 period", p, 1 << e);
      old_p = 1 << e;
    end
    hi = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (timer_ce) hi++;
    end
    chk(hi == 300, "R3 timer undivided", hi, 300);
  endtask

  task automatic t_sources;
    int p;
    send(1'b0, 1, 1, 1'b0, 1'b0);
    measure(p);
    chk(src_sel == 2'd1 && p == 2, "R4 rtc select", src_sel, 1);
    send(1'b0, 1, 2, 1'b1, 1'b0);
    measure(p);
    chk(src_sel == 2'd2, "R4 pll select", src_sel, 2);
    chk(!osc_en && pll_en, "R5 main off", {osc_en, pll_en}, 1);
    send(1'b0, 1, 1, 1'b1, 1'b1);
    measure(p);
    chk(!osc_en && !pll_en, "R5 both off", {osc_en, pll_en}, 0);
    send(1'b0, 1, 0, 1'b0, 1'b0);
    measure(p);
    chk(osc_en && pll_en && src_sel == 2'd0, "R5 restored", {osc_en, pll_en}, 3);
  endtask

  task automatic t_reject;
    int p;
    send(1'b0, 2, 2, 1'b0, 1'b0);
    measure(p);
    chk(p == 4 && src_sel == 2'd2, "R7 baseline", p, 4);
    send(1'b0, 5, 3, 1'b0, 1'b0);
    measure(p);
    chk(p == 4 && src_sel == 2'd2, "R7 reserved source", p, 4);
    send(1'b0, 5, 2, 1'b0, 1'b1);
    measure(p);
    chk(p == 4 && pll_en, "R7 pll off while selected", p, 4);
    send(1'b0, 5, 0, 1'b1, 1'b0);
    measure(p);
    chk(p == 4 && src_sel == 2'd2, "R7 main off while selected", src_sel, 2);
  endtask

  task automatic t_irq;
    int p;
    send(1'b0, 1, 0, 1'b0, 1'b0);
    send(1'b1, 3, 1, 1'b0, 1'b0);
    measure(p);
    chk(p == 2 && src_sel == 2'd0, "R8 isr write leaves normal", p, 2);
    irq(1'b1, 1'b0);
    measure(p);
    chk(p == 8 && src_sel == 2'd1, "R9 enter switches", p, 8);
    irq(1'b1, 1'b0);
    irq(1'b0, 1'b1);
    measure(p);
    chk(p == 8, "R10 inner return keeps isr", p, 8);
    irq(1'b1, 1'b1);
    measure(p);
    chk(p == 8, "R11 both at depth 1", p, 8);
    irq(1'b0, 1'b1);
    measure(p);
    chk(p == 2 && src_sel == 2'd0, "R9 outer return restores", p, 2);
    irq(1'b0, 1'b1);
    irq(1'b1, 1'b0);
    measure(p);
    chk(p == 8, "R10 stray return ignored", p, 8);
    irq(1'b0, 1'b1);
    for (int i = 0; i < 16; i++) irq(1'b1, 1'b0);
    for (int i = 0; i < 14; i++) irq(1'b0, 1'b1);
    measure(p);
    chk(p == 8, "R10 depth saturates", p, 8);
    irq(1'b0, 1'b1);
    measure(p);
    chk(p == 2, "R10 final return", p, 2);
    irq(1'b1, 1'b1);
    measure(p);
    chk(p == 2, "R11 both at depth 0", p, 2);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_div_sweep();
    t_sources();
    t_reject();
    t_irq();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule